// File: doc/BRIEF.md
# Store Queue with Load Ordering Check

This block keeps memory operations in order inside an out-of-order core. Stores are taken into a circular queue in program order when they issue, and their address and data arrive later, in any order, by queue slot. Loads are taken into a separate buffer with their address. When a load enters, it captures the store-queue tail pointer. From that moment, the stores that lie between the current head and that captured tail are exactly the stores older than the load. No later store can hold the load back or feed it data.

Each cycle the block checks every buffered load against its older stores. A load waits while any older store has an unknown address. If older stores share its address, the youngest of them decides the outcome. When that store holds its data, the load leaves with the forwarded value and no memory access is needed. When it does not, the load keeps waiting. A load with no matching older store leaves as a memory request. At most one load leaves per cycle, and it is the oldest ready one by reorder-buffer tag. Stores retire from the head on commit. A flush drops every store and load younger than a given tag and rolls the store tail back.

Top module: `mem_order_queue`

## Requirements
- R1: After reset, stAllocReady and ldAllocReady are 1, ldLaunchValid is 0 and stAllocIdx is 0.
- R2: The store queue holds 8 stores. stAllocIdx names the slot the next store takes and advances by one, modulo 8, for each accepted store. stAllocReady is 0 while 8 stores are held, and a store offered then is ignored.
- R3: The load buffer holds 8 loads. ldAllocReady is 0 while 8 loads are held, and a load offered then is ignored.
- R4: A load that has no older stores launches in the cycle after it is accepted, with ldLaunchFwd 0.
- R5: A load does not launch while any older store has an unknown address. A store accepted in the same cycle as a load, or later, counts as younger and never blocks it.
- R6: If older stores have the load's address, the youngest of them decides. The load waits until that store has data, then launches with ldLaunchFwd 1 and ldLaunchData equal to that store's data.
- R7: A load whose older stores all have known, non-matching addresses launches with ldLaunchFwd 0, ldLaunchData 0, and ldLaunchAddr equal to its own address.
- R8: At most one load launches per cycle, and it is the ready load with the oldest tag. Tags are 6 bits, and tag a is older than tag b when (a - b) mod 64 is 32 or more.
- R9: stCommit removes the head store and shows that store's address and data on stCommitAddr and stCommitData in the same cycle. stCommit on an empty queue is ignored.
- R10: flushValid removes every store and load whose tag is strictly younger than flushTag. The next stAllocIdx becomes the first removed slot. Allocations and launches offered in the flush cycle are dropped.
- R11: Store slots wrap from 7 back to 0, and the older and younger store sets stay correct after the pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stAllocValid | input | 1 | Allocate a store this cycle |
| stAllocTag | input | 6 | Reorder-buffer tag of the new store |
| stAllocReady | output | 1 | Store queue has room |
| stAllocIdx | output | 3 | Slot that the next store takes |
| stAddrValid | input | 1 | Write a store address |
| stAddrIdx | input | 3 | Slot for the address write |
| stAddr | input | 32 | Store word address |
| stDataValid | input | 1 | Write store data |
| stDataIdx | input | 3 | Slot for the data write |
| stData | input | 32 | Store data |
| stCommit | input | 1 | Retire the head store |
| stCommitAddr | output | 32 | Address of the head store |
| stCommitData | output | 32 | Data of the head store |
| ldAllocValid | input | 1 | Allocate a load this cycle |
| ldAllocTag | input | 6 | Reorder-buffer tag of the new load |
| ldAllocAddr | input | 32 | Load word address |
| ldAllocReady | output | 1 | Load buffer has room |
| ldLaunchValid | output | 1 | A load launches this cycle |
| ldLaunchTag | output | 6 | Tag of the launching load |
| ldLaunchAddr | output | 32 | Address of the launching load |
| ldLaunchFwd | output | 1 | Load is served by forwarding |
| ldLaunchData | output | 32 | Forwarded data, or 0 |
| flushValid | input | 1 | Flush younger entries |
| flushTag | input | 6 | Entries younger than this tag are removed |

## Verification
The assertions rely on four conditions on the inputs:
- Live tags are unique and lie within 32 of each other.
- A store is committed only after every load that depends on it has left.
- Address and data writes target live slots only.
- A flush cycle carries no fill or commit.

The bench keeps to these conditions in several ways. It tracks the oldest live sequence number and stops allocating before the window grows too wide. It commits only a head store that is fully known and older than every pending load. It writes only to live slots, and it drives a flush cycle with nothing else. Addresses come from a set of four words, so matches, youngest-match selection and forwarding occur often.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;
  // Queue depths must be powers of two for pointer wrap.
  localparam int SQ_DEPTH = 8;
  localparam int LB_DEPTH = 8;
  localparam int TAG_W    = 6;
  localparam int SQ_IW    = $clog2(SQ_DEPTH);
  localparam int SQ_PW    = SQ_IW + 1;
  localparam int LB_IW    = $clog2(LB_DEPTH);

  typedef logic [SQ_IW-1:0] sqIdx_t;
  typedef logic [SQ_PW-1:0] sqPtr_t;
  typedef logic [LB_IW-1:0] lbIdx_t;
  typedef logic [TAG_W-1:0] robTag_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   stAlloc;
    sqIdx_t stIdx;
    logic   ldAlloc;
    lbIdx_t ldIdx;
    sqPtr_t tailSnap;
    logic   commit;
    sqPtr_t head;
    logic   launch;
    lbIdx_t launchIdx;
    logic   flush;
  } lsqStrobe_t;

  // a is older than b when the modular difference is negative
  function automatic logic isOlder(robTag_t a, robTag_t b);
    robTag_t d;
    d = a - b;
    return d[TAG_W-1];
  endfunction
endpackage

// File: rtl/lsq_ctrl.sv
`timescale 1ns/1ps
module lsq_ctrl
  import lsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stAllocValid,
  input  logic       stCommit,
  input  logic       ldAllocValid,
  input  logic       flushValid,
  input  logic [LB_DEPTH-1:0] ldValid,
  input  logic [LB_DEPTH-1:0] ldEligible,
  input  robTag_t    ldTag [LB_DEPTH],
  input  sqPtr_t     survivors,
  output lsqStrobe_t strb,
  output logic       stAllocReady,
  output logic       ldAllocReady
);
  sqPtr_t headQ, tailQ, used;
  logic   freeFound, pickFound;
  lbIdx_t freeIdx, pickIdx;

  assign used         = tailQ - headQ;
  assign stAllocReady = (used != SQ_PW'(SQ_DEPTH));
  assign ldAllocReady = freeFound;

  // lowest free load slot
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = LB_DEPTH - 1; i >= 0; i--) begin
      if (!ldValid[i]) begin
        freeFound = 1'b1;
        freeIdx   = LB_IW'(i);
      end
    end
  end

  // oldest eligible load by tag
  always_comb begin
    pickFound = 1'b0;
    pickIdx   = '0;
    for (int i = 0; i < LB_DEPTH; i++) begin
      if (ldEligible[i] && (!pickFound || isOlder(ldTag[i], ldTag[pickIdx]))) begin
        pickFound = 1'b1;
        pickIdx   = LB_IW'(i);
      end
    end
  end

  always_comb begin
    strb.stAlloc   = stAllocValid && stAllocReady && !flushValid;
    strb.stIdx     = tailQ[SQ_IW-1:0];
    strb.ldAlloc   = ldAllocValid && freeFound && !flushValid;
    strb.ldIdx     = freeIdx;
    strb.tailSnap  = tailQ;
    strb.commit    = stCommit && (used != '0);
    strb.head      = headQ;
    strb.launch    = pickFound && !flushValid;
    strb.launchIdx = pickIdx;
    strb.flush     = flushValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headQ <= '0;
      tailQ <= '0;
    end else begin
      if (strb.commit) headQ <= headQ + SQ_PW'(1);
      if (flushValid) tailQ <= headQ + survivors;
      else if (strb.stAlloc) tailQ <= tailQ + SQ_PW'(1);
    end
  end
endmodule

// File: rtl/lsq_datapath.sv
`timescale 1ns/1ps
module lsq_datapath
  import lsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lsqStrobe_t        strb,
  input  robTag_t           stAllocTag,
  input  logic              stAddrValid,
  input  sqIdx_t            stAddrIdx,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              stDataValid,
  input  sqIdx_t            stDataIdx,
  input  logic [DATA_W-1:0] stData,
  input  robTag_t           ldAllocTag,
  input  logic [ADDR_W-1:0] ldAllocAddr,
  input  robTag_t           flushTag,
  output logic [LB_DEPTH-1:0] ldValidO,
  output logic [LB_DEPTH-1:0] ldEligibleO,
  output robTag_t           ldTagO [LB_DEPTH],
  output sqPtr_t            survivors,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [DATA_W-1:0] commitData,
  output robTag_t           launchTag,
  output logic [ADDR_W-1:0] launchAddr,
  output logic              launchFwd,
  output logic [DATA_W-1:0] launchData
);
  logic [SQ_DEPTH-1:0] stValid, stAddrKnown, stDataKnown;
  robTag_t             stTag     [SQ_DEPTH];
  logic [ADDR_W-1:0]   stAddrMem [SQ_DEPTH];
  logic [DATA_W-1:0]   stDataMem [SQ_DEPTH];

  logic [LB_DEPTH-1:0] ldValid;
  robTag_t             ldTag     [LB_DEPTH];
  logic [ADDR_W-1:0]   ldAddrMem [LB_DEPTH];
  sqPtr_t              ldSnap    [LB_DEPTH];
  logic [LB_DEPTH-1:0] ldHit;
  sqIdx_t              ldHitIdx  [LB_DEPTH];

  assign ldValidO = ldValid;
  assign ldTagO   = ldTag;

  // per-load ordering check against its older stores
  for (genvar l = 0; l < LB_DEPTH; l++) begin : g_ld
    sqPtr_t span;
    sqIdx_t slot;
    sqIdx_t hitIdx;
    logic   blocked, hit;
    always_comb begin
      span    = ldSnap[l] - strb.head;
      blocked = 1'b0;
      hit     = 1'b0;
      hitIdx  = '0;
      slot    = '0;
      for (int k = 0; k < SQ_DEPTH; k++) begin
        slot = strb.head[SQ_IW-1:0] + SQ_IW'(k);
        if ((SQ_PW'(k) < span) && stValid[slot]) begin
          if (!stAddrKnown[slot]) blocked = 1'b1;
          else if (stAddrMem[slot] == ldAddrMem[l]) begin
            hit    = 1'b1;
            hitIdx = slot;   // later offset = younger store
          end
        end
      end
    end
    assign ldEligibleO[l] = ldValid[l] && !blocked && (!hit || stDataKnown[hitIdx]);
    assign ldHit[l]       = hit;
    assign ldHitIdx[l]    = hitIdx;
  end

  always_comb begin
    survivors = '0;
    for (int i = 0; i < SQ_DEPTH; i++)
      if (stValid[i] && !isOlder(flushTag, stTag[i])) survivors = survivors + SQ_PW'(1);
  end

  assign commitAddr = stAddrMem[strb.head[SQ_IW-1:0]];
  assign commitData = stDataMem[strb.head[SQ_IW-1:0]];
  assign launchTag  = ldTag[strb.launchIdx];
  assign launchAddr = ldAddrMem[strb.launchIdx];
  assign launchFwd  = strb.launch && ldHit[strb.launchIdx];
  assign launchData = launchFwd ? stDataMem[ldHitIdx[strb.launchIdx]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stValid <= '0;
      ldValid <= '0;
    end else begin
      if (strb.commit) stValid[strb.head[SQ_IW-1:0]] <= 1'b0;
      if (strb.launch) ldValid[strb.launchIdx] <= 1'b0;
      if (strb.flush) begin
        for (int i = 0; i < SQ_DEPTH; i++)
          if (stValid[i] && isOlder(flushTag, stTag[i])) stValid[i] <= 1'b0;
        for (int i = 0; i < LB_DEPTH; i++)
          if (ldValid[i] && isOlder(flushTag, ldTag[i])) ldValid[i] <= 1'b0;
      end
      if (strb.stAlloc) stValid[strb.stIdx] <= 1'b1;
      if (strb.ldAlloc) ldValid[strb.ldIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stAddrValid) begin
      stAddrMem[stAddrIdx]   <= stAddr;
      stAddrKnown[stAddrIdx] <= 1'b1;
    end
    if (stDataValid) begin
      stDataMem[stDataIdx]   <= stData;
      stDataKnown[stDataIdx] <= 1'b1;
    end
    if (strb.stAlloc) begin
      stTag[strb.stIdx]       <= stAllocTag;
      stAddrKnown[strb.stIdx] <= 1'b0;
      stDataKnown[strb.stIdx] <= 1'b0;
    end
    if (strb.ldAlloc) begin
      ldTag[strb.ldIdx]     <= ldAllocTag;
      ldAddrMem[strb.ldIdx] <= ldAllocAddr;
      ldSnap[strb.ldIdx]    <= strb.tailSnap;
    end
  end
endmodule

// File: rtl/mem_order_queue.sv
`timescale 1ns/1ps
module mem_order_queue
  import lsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stAllocValid,
  input  logic [TAG_W-1:0]  stAllocTag,
  output logic              stAllocReady,
  output logic [SQ_IW-1:0]  stAllocIdx,
  input  logic              stAddrValid,
  input  logic [SQ_IW-1:0]  stAddrIdx,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              stDataValid,
  input  logic [SQ_IW-1:0]  stDataIdx,
  input  logic [DATA_W-1:0] stData,
  input  logic              stCommit,
  output logic [ADDR_W-1:0] stCommitAddr,
  output logic [DATA_W-1:0] stCommitData,
  input  logic              ldAllocValid,
  input  logic [TAG_W-1:0]  ldAllocTag,
  input  logic [ADDR_W-1:0] ldAllocAddr,
  output logic              ldAllocReady,
  output logic              ldLaunchValid,
  output logic [TAG_W-1:0]  ldLaunchTag,
  output logic [ADDR_W-1:0] ldLaunchAddr,
  output logic              ldLaunchFwd,
  output logic [DATA_W-1:0] ldLaunchData,
  input  logic              flushValid,
  input  logic [TAG_W-1:0]  flushTag
);
  lsqStrobe_t          strb;
  logic [LB_DEPTH-1:0] ldValid, ldEligible;
  robTag_t             ldTag [LB_DEPTH];
  sqPtr_t              survivors;

  lsq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .stAllocValid(stAllocValid), .stCommit(stCommit),
    .ldAllocValid(ldAllocValid), .flushValid(flushValid),
    .ldValid(ldValid), .ldEligible(ldEligible), .ldTag(ldTag),
    .survivors(survivors), .strb(strb),
    .stAllocReady(stAllocReady), .ldAllocReady(ldAllocReady)
  );

  lsq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .stAllocTag(stAllocTag),
    .stAddrValid(stAddrValid), .stAddrIdx(stAddrIdx), .stAddr(stAddr),
    .stDataValid(stDataValid), .stDataIdx(stDataIdx), .stData(stData),
    .ldAllocTag(ldAllocTag), .ldAllocAddr(ldAllocAddr), .flushTag(flushTag),
    .ldValidO(ldValid), .ldEligibleO(ldEligible), .ldTagO(ldTag),
    .survivors(survivors),
    .commitAddr(stCommitAddr), .commitData(stCommitData),
    .launchTag(ldLaunchTag), .launchAddr(ldLaunchAddr),
    .launchFwd(ldLaunchFwd), .launchData(ldLaunchData)
  );

  assign ldLaunchValid = strb.launch;
  assign stAllocIdx    = strb.stIdx;
endmodule

// File: rtl/mem_order_queue_checker.sv
`timescale 1ns/1ps
module mem_order_queue_checker
  import lsq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stAllocValid,
  input logic             stAllocReady,
  input logic [SQ_IW-1:0] stAllocIdx,
  input logic             ldAllocReady,
  input logic             ldLaunchValid,
  input logic [TAG_W-1:0] ldLaunchTag,
  input logic             ldLaunchFwd,
  input logic             flushValid
);
  // R2: an accepted store moves the allocation slot on by one
  p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stAllocValid && stAllocReady && !flushValid) |=> (stAllocIdx == SQ_IW'($past(stAllocIdx) + 1'b1)));

  // R2: a full queue without a flush keeps its allocation slot
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stAllocReady && !flushValid) |=> (stAllocIdx == $past(stAllocIdx)));

  // R3: a launch frees a load slot for the following cycle
  p_slot_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ldLaunchValid |=> ldAllocReady);

  // R8: a launched load does not launch again
  p_launch_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ldLaunchValid |=> !(ldLaunchValid && (ldLaunchTag == $past(ldLaunchTag))));

  // R6: forwarding is reported only with a launch
  p_fwd_with_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ldLaunchFwd |-> ldLaunchValid);
endmodule

bind mem_order_queue mem_order_queue_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stAllocValid(stAllocValid),
  .stAllocReady(stAllocReady), .stAllocIdx(stAllocIdx),
  .ldAllocReady(ldAllocReady), .ldLaunchValid(ldLaunchValid),
  .ldLaunchTag(ldLaunchTag), .ldLaunchFwd(ldLaunchFwd),
  .flushValid(flushValid)
);

// File: tb/tb_mem_order_queue.sv
`timescale 1ns/1ps
module tb_mem_order_queue;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stAllocValid, stAddrValid, stDataValid, stCommit, ldAllocValid, flushValid;
  logic [5:0]  stAllocTag, ldAllocTag, flushTag, ldLaunchTag;
  logic [2:0]  stAllocIdx, stAddrIdx, stDataIdx;
  logic [31:0] stAddr, stData, ldAllocAddr, stCommitAddr, stCommitData, ldLaunchAddr, ldLaunchData;
  logic stAllocReady, ldAllocReady, ldLaunchValid, ldLaunchFwd;

  always #2.5 clk = ~clk;

  mem_order_queue dut (.*);

  int nChecks = 0, nFail = 0;
  int nextSeq = 1, stSeqDrv, ldSeqDrv, flushSeq;
  // bench model, in program-order sequence numbers
  int mStSeq[8]; bit mStAK[8], mStDK[8]; logic [31:0] mStA[8], mStD[8];
  int mHead = 0, mTail = 0;
  bit mLdV[8]; int mLdSeq[8]; logic [31:0] mLdA[8]; int mLdSnap[8];

  task automatic chk(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ldCount();
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(mLdV[i]);
    return n;
  endfunction

  function automatic int oldestLive();
    int o = nextSeq;
    for (int p = mHead; p < mTail; p++) if (mStSeq[p % 8] < o) o = mStSeq[p % 8];
    for (int i = 0; i < 8; i++) if (mLdV[i] && mLdSeq[i] < o) o = mLdSeq[i];
    return o;
  endfunction

  function automatic int minLoadSeq();
    int o = 32'h7fffffff;
    for (int i = 0; i < 8; i++) if (mLdV[i] && mLdSeq[i] < o) o = mLdSeq[i];
    return o;
  endfunction

  function automatic bit stLive(int s);
    return ((s - (mHead % 8) + 8) % 8) < (mTail - mHead);
  endfunction

  // expected launch from the ordering rules
  function automatic void expLaunch(output bit v, output int slot, output bit fwd, output logic [31:0] data);
    v = 0; slot = 0; fwd = 0; data = '0;
    for (int l = 0; l < 8; l++) begin
      bit blocked = 0, hit = 0, hk = 0;
      logic [31:0] hd = '0;
      if (!mLdV[l]) continue;
      for (int p = mHead; p < mLdSnap[l]; p++) begin
        if (!mStAK[p % 8]) blocked = 1;
        else if (mStA[p % 8] == mLdA[l]) begin hit = 1; hk = mStDK[p % 8]; hd = mStD[p % 8]; end
      end
      if (!blocked && (!hit || hk) && (!v || mLdSeq[l] < mLdSeq[slot])) begin
        v = 1; slot = l; fwd = hit; data = hit ? hd : '0;
      end
    end
  endfunction

  task automatic clearIn();
    stAllocValid = 0; stAddrValid = 0; stDataValid = 0; stCommit = 0;
    ldAllocValid = 0; flushValid = 0;
    stAllocTag = '0; ldAllocTag = '0; flushTag = '0; stAddrIdx = '0; stDataIdx = '0;
    stAddr = '0; stData = '0; ldAllocAddr = '0;
  endtask

  task automatic runCycle();
    bit ev, ef, stAcc, ldAcc, cmAcc; int es; logic [31:0] ed;
    #1;
    expLaunch(ev, es, ef, ed);
    if (flushValid) ev = 0;
    chk(stAllocReady == (mTail - mHead < 8), "R2", stAllocReady, (mTail - mHead < 8));
    chk(ldAllocReady == (ldCount() < 8), "R3", ldAllocReady, (ldCount() < 8));
    chk(stAllocIdx == 3'(mTail % 8), "R11", stAllocIdx, mTail % 8);
    chk(ldLaunchValid == ev, ev ? (ef ? "R6" : "R7") : "R5", ldLaunchValid, ev);
    if (ev && ldLaunchValid) begin
      chk(ldLaunchTag == 6'(mLdSeq[es]), "R8", ldLaunchTag, 6'(mLdSeq[es]));
      chk(ldLaunchAddr == mLdA[es], "R7", ldLaunchAddr, mLdA[es]);
      chk(ldLaunchFwd == ef, "R6", ldLaunchFwd, ef);
      chk(ldLaunchData == ed, "R6", ldLaunchData, ed);
    end
    cmAcc = stCommit && (mTail > mHead) && !flushValid;
    if (cmAcc) begin
      if (mStAK[mHead % 8]) chk(stCommitAddr == mStA[mHead % 8], "R9", stCommitAddr, mStA[mHead % 8]);
      if (mStDK[mHead % 8]) chk(stCommitData == mStD[mHead % 8], "R9", stCommitData, mStD[mHead % 8]);
    end
    if (flushValid) begin
      int cnt = 0;
      for (int i = 0; i < 8; i++) if (mLdV[i] && mLdSeq[i] > flushSeq) mLdV[i] = 0;
      for (int p = mHead; p < mTail; p++) if (mStSeq[p % 8] <= flushSeq) cnt++;
      mTail = mHead + cnt;
    end else begin
      stAcc = stAllocValid && (mTail - mHead < 8);
      ldAcc = ldAllocValid && (ldCount() < 8);
      if (ev) mLdV[es] = 0;
      if (cmAcc) mHead++;
      if (stAddrValid) begin mStAK[stAddrIdx] = 1; mStA[stAddrIdx] = stAddr; end
      if (stDataValid) begin mStDK[stDataIdx] = 1; mStD[stDataIdx] = stData; end
      if (ldAcc) begin
        for (int i = 0; i < 8; i++) if (!mLdV[i]) begin
          mLdV[i] = 1; mLdSeq[i] = ldSeqDrv; mLdA[i] = ldAllocAddr; mLdSnap[i] = mTail;
          break;
        end
      end
      if (stAcc) begin
        mStSeq[mTail % 8] = stSeqDrv; mStAK[mTail % 8] = 0; mStDK[mTail % 8] = 0;
        mTail++;
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic driveStore();
    stAllocValid = 1; stSeqDrv = nextSeq++; stAllocTag = 6'(stSeqDrv);
  endtask

  task automatic driveLoad(logic [31:0] a);
    ldAllocValid = 1; ldSeqDrv = nextSeq++; ldAllocTag = 6'(ldSeqDrv); ldAllocAddr = a;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    clearIn();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(stAllocReady == 1 && ldAllocReady == 1, "R1", {stAllocReady, ldAllocReady}, 2'b11);
    chk(ldLaunchValid == 0 && stAllocIdx == 0, "R1", {ldLaunchValid, stAllocIdx}, 0);

    // R4: load with no older stores
    clearIn(); driveLoad(32'h5); runCycle();
    clearIn();
    chk(ldLaunchValid == 1 && ldLaunchFwd == 0, "R4", {ldLaunchValid, ldLaunchFwd}, 2'b10);
    runCycle();

    // R2: fill the store queue, then offer one more
    for (int i = 0; i < 8; i++) begin clearIn(); driveStore(); runCycle(); end
    clearIn();
    chk(stAllocReady == 0, "R2", stAllocReady, 0);
    driveStore(); runCycle();
    chk(stAllocIdx == 3'd0, "R2", stAllocIdx, 0);

    // R5/R6: load behind unknown stores; matches at slots 3 and 5
    clearIn(); driveLoad(32'h1); runCycle();
    for (int k = 0; k < 8; k++) begin
      clearIn();
      stAddrValid = 1; stAddrIdx = 3'(k); stAddr = (k == 3 || k == 5) ? 32'h1 : 32'h9;
      if (k == 3) begin stDataValid = 1; stDataIdx = 3'd3; stData = 32'h3333; end
      chk(ldLaunchValid == 0, "R5", ldLaunchValid, 0);
      runCycle();
    end
    clearIn();
    chk(ldLaunchValid == 0, "R6", ldLaunchValid, 0);
    stDataValid = 1; stDataIdx = 3'd5; stData = 32'hBEEF;
    runCycle();
    clearIn();
    chk(ldLaunchFwd == 1 && ldLaunchData == 32'hBEEF, "R6", ldLaunchData, 32'hBEEF);
    runCycle();

    // R10: flush keeps slots 0..4 and drops a store offered with it
    clearIn();
    flushValid = 1; flushSeq = mStSeq[4]; flushTag = 6'(flushSeq);
    driveStore();
    runCycle();
    clearIn();
    chk(stAllocIdx == 3'd5 && stAllocReady == 1, "R10", stAllocIdx, 5);

    // R9: drain the queue, then commit on empty
    for (int i = 0; i < 5; i++) begin
      clearIn();
      stDataValid = 1; stDataIdx = 3'(i); stData = 32'(i + 100);
      runCycle();
      clearIn(); stCommit = 1; runCycle();
    end
    clearIn(); stCommit = 1; runCycle();
    clearIn();
    chk(stAllocIdx == 3'd5 && stAllocReady == 1, "R9", stAllocIdx, 5);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      int oldest, s;
      clearIn();
      oldest = oldestLive();
      if (oldest < nextSeq && $urandom_range(0, 39) == 0) begin
        flushValid = 1;
        flushSeq = oldest + int'($urandom_range(0, nextSeq - 1 - oldest));
        flushTag = 6'(flushSeq);
      end else begin
        if (nextSeq + 2 - oldest < 28) begin
          if ($urandom_range(0, 9) < 4) driveLoad(32'($urandom_range(0, 3)));
          if ($urandom_range(0, 9) < 4) driveStore();
        end
        s = int'($urandom_range(0, 7));
        if ($urandom_range(0, 9) < 4 && stLive(s) && !mStAK[s]) begin
          stAddrValid = 1; stAddrIdx = 3'(s); stAddr = 32'($urandom_range(0, 3));
        end
        s = int'($urandom_range(0, 7));
        if ($urandom_range(0, 9) < 4 && stLive(s) && !mStDK[s]) begin
          stDataValid = 1; stDataIdx = 3'(s); stData = $urandom;
        end
        if (mTail > mHead) begin
          s = mHead % 8;
          if (mStAK[s] && mStDK[s] && mStSeq[s] < minLoadSeq() && $urandom_range(0, 9) < 3)
            stCommit = 1;
        end else if ($urandom_range(0, 9) == 0) stCommit = 1;
      end
      runCycle();
    end
    finishRun();
  end
endmodule